// File: doc/BRIEF.md
# Predicated Multi-Register Vector Select

This block produces the write-back data for a group of two or four destination vector registers. Each element of every destination vector is copied from the matching element of a first source group when that element is active, and from the matching element of a second source group when it is not. Activity is decided by a single count-style predicate, and that predicate spans the whole group. Its low 16 bits hold a count of active elements. Element positions are numbered across the group in register order, and every position below the count is active.

The block drives the read addresses for the register file and gets the read data back in the same cycle. It also drives the address of the governing predicate register. A one-cycle `start` pulse captures the selected results. One cycle later the block presents them on the write-back ports, together with `done` and a per-register write enable. All results come from data sampled at the `start` edge. Because of this, a destination group that overlaps a source group still produces results built from the old source values.

Top module: `vsel_group`

## Requirements
- R1: `esz` selects the element width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Every byte of an element shares that element's active state.
- R2: When `quad`=1, a completed operation writes four registers and `wb_en`=4'b1111. When `quad`=0, it writes two registers and `wb_en`=4'b0011. Outside the `done` cycle, `wb_en` is 0.
- R3: The base index of a group is its field times 2 when `quad`=0. When `quad`=1, it is the low three bits of the field times 4. Member k of a group uses base+k, and addresses wrap modulo 2^RFW. Slots 0..3 of `src_addr` carry the first group and slots 4..7 carry the second. Slot k of `wb_addr` carries destination member k.
- R4: `pred_addr` is `{1'b1, pn_fld}`, which selects predicate register 8 to 15.
- R5: The count is the low 16 bits of `pred_data`. Element e of member k has group position k*(VLEN/width)+e, and that element is active when its position is below the count. A count at or above the group's element total makes every element active.
- R6: An active element takes the first-source value. An inactive element takes the second-source value.
- R7: `done` and valid write-back data appear exactly one cycle after `start`, whatever the data. `done` is low in every other cycle.
- R8: Results are taken from the read data present at the `start` edge. They stay unchanged until the next `start`.
- R9: After reset, `done`=0, `wb_en`=0 and `wb_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Operation strobe |
| esz | input | 2 | Element size code |
| quad | input | 1 | 1: four-register group, 0: two-register group |
| dst_fld | input | RFW-1 | Destination group field |
| srca_fld | input | RFW-1 | First source group field |
| srcb_fld | input | RFW-1 | Second source group field |
| pn_fld | input | 3 | Predicate register field |
| src_addr | output | 8*RFW | Register-file read addresses |
| src_data | input | 8*VLEN | Register-file read data, one vector per slot |
| pred_addr | output | 4 | Predicate register read address |
| pred_data | input | VLEN/8 | Predicate read data |
| wb_en | output | 4 | Per-register write enable |
| wb_addr | output | 4*RFW | Destination register indices |
| wb_data | output | 4*VLEN | Destination data |
| done | output | 1 | Results valid |

## Verification
A fault in the count comparison or in the element-size shift moves the boundary between first-source and second-source data. That shows up in the very first `done` cycle, as bytes near the count boundary that come from the wrong group. A fault in the base computation shows up at once on `src_addr`, in the same cycle as the inputs. A fault in the capture register or the enable shows up one cycle after `start`, as a missing or extra `done` or data that fails to hold.

// File: rtl/vsel_group.sv
module vsel_group #(
  parameter int VLEN = 128,
  parameter int RFW  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           esz,
  input  logic                 quad,
  input  logic [RFW-2:0]       dst_fld,
  input  logic [RFW-2:0]       srca_fld,
  input  logic [RFW-2:0]       srcb_fld,
  input  logic [2:0]           pn_fld,
  output logic [8*RFW-1:0]     src_addr,
  input  logic [8*VLEN-1:0]    src_data,
  output logic [3:0]           pred_addr,
  input  logic [VLEN/8-1:0]    pred_data,
  output logic [3:0]           wb_en,
  output logic [4*RFW-1:0]     wb_addr,
  output logic [4*VLEN-1:0]    wb_data,
  output logic                 done
);
  localparam int PL = VLEN / 8;

  logic [RFW-1:0]    a_base, b_base, d_base;
  logic [15:0]       cnt;
  logic [4*PL-1:0]   act;
  logic [4*VLEN-1:0] sel;
  logic [4*RFW-1:0]  d_addr;

  assign a_base = quad ? {srca_fld[2:0], 2'b00} : {srca_fld, 1'b0};
  assign b_base = quad ? {srcb_fld[2:0], 2'b00} : {srcb_fld, 1'b0};
  assign d_base = quad ? {dst_fld[2:0], 2'b00}  : {dst_fld, 1'b0};
  assign pred_addr = {1'b1, pn_fld};
  assign cnt = pred_data[15:0];

  for (genvar r = 0; r < 4; r++) begin : g_reg
    assign src_addr[r*RFW +: RFW]     = a_base + RFW'(r);
    assign src_addr[(4+r)*RFW +: RFW] = b_base + RFW'(r);
    assign d_addr[r*RFW +: RFW]       = d_base + RFW'(r);
    for (genvar b = 0; b < PL; b++) begin : g_byte
      localparam int GB = r * PL + b;
      assign act[GB] = (32'(GB) >> esz) < {16'b0, cnt};
      assign sel[r*VLEN + b*8 +: 8] = act[GB] ? src_data[r*VLEN + b*8 +: 8]
                                              : src_data[(4+r)*VLEN + b*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      wb_en   <= 4'b0;
      wb_addr <= '0;
      wb_data <= '0;
    end else begin
      done  <= start;
      wb_en <= start ? (quad ? 4'b1111 : 4'b0011) : 4'b0000;
      if (start) begin
        wb_addr <= d_addr;
        wb_data <= sel;
      end
    end
  end
endmodule

module vsel_group_chk #(
  parameter int VLEN = 128,
  parameter int RFW  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              quad,
  input logic [8*VLEN-1:0] src_data,
  input logic [VLEN/8-1:0] pred_data,
  input logic [3:0]        wb_en,
  input logic [4*RFW-1:0]  wb_addr,
  input logic [4*VLEN-1:0] wb_data,
  input logic              done
);
  assert_done_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  assert_no_stray_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  assert_enable_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (wb_en == ($past(quad) ? 4'b1111 : 4'b0011)));
  assert_enable_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> wb_en == 4'b0);
  assert_quad_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && quad) |=> wb_addr[1:0] == 2'b00);
  assert_zero_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && pred_data[15:0] == 16'd0) |=> wb_data[VLEN-1:0] == $past(src_data[4*VLEN +: VLEN]));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(wb_data));
endmodule

bind vsel_group vsel_group_chk #(.VLEN(VLEN), .RFW(RFW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .quad(quad), .src_data(src_data),
  .pred_data(pred_data), .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data), .done(done)
);

// File: tb/vsel_group_bench.sv
`timescale 1ns/1ps
module vsel_group_bench;
  localparam int VLEN = 128;
  localparam int RFW  = 5;
  localparam int PL   = VLEN / 8;

  logic clk = 0, rst_n = 0, start = 0, quad = 0;
  logic [1:0] esz = 0;
  logic [RFW-2:0] dst_fld = 0, srca_fld = 0, srcb_fld = 0;
  logic [2:0] pn_fld = 0;
  logic [8*RFW-1:0] src_addr;
  logic [8*VLEN-1:0] src_data;
  logic [3:0] pred_addr;
  logic [PL-1:0] pred_data;
  logic [3:0] wb_en;
  logic [4*RFW-1:0] wb_addr;
  logic [4*VLEN-1:0] wb_data;
  logic done;

  logic [VLEN-1:0] rf [32];
  logic [PL-1:0]   prf [16];
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  vsel_group #(.VLEN(VLEN), .RFW(RFW)) u_vsel_group (.*);

  always_comb begin
    for (int s = 0; s < 8; s++) src_data[s*VLEN +: VLEN] = rf[src_addr[s*RFW +: RFW]];
    pred_data = prf[pred_addr];
  end

  task automatic chk(string req, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int base_of(int f, bit q);
    return q ? (f % 8) * 4 : f * 2;
  endfunction

  task automatic run_op(string req, int sz, bit q, int d, int a, int b, int g, int count);
    logic [VLEN-1:0] exp [4];
    int nr = q ? 4 : 2;
    int eb = 1 << sz;
    int per = PL / eb;
    int ab = base_of(a, q), bb = base_of(b, q), db = base_of(d, q);
    prf[8 + g] = PL'(count);
    for (int r = 0; r < nr; r++)
      for (int by = 0; by < PL; by++) begin
        int pos = r * per + by / eb;
        exp[r][by*8 +: 8] = (pos < count) ? rf[(ab + r) % 32][by*8 +: 8]
                                          : rf[(bb + r) % 32][by*8 +: 8];
      end
    @(negedge clk);
    esz = 2'(sz); quad = q; dst_fld = (RFW-1)'(d); srca_fld = (RFW-1)'(a);
    srcb_fld = (RFW-1)'(b); pn_fld = 3'(g); start = 1;
    #1;
    chk({req, " R4 pred_addr"}, VLEN'(pred_addr), VLEN'(8 + g));
    for (int r = 0; r < nr; r++) begin
      chk({req, " R3 src a"}, VLEN'(src_addr[r*RFW +: RFW]), VLEN'((ab + r) % 32));
      chk({req, " R3 src b"}, VLEN'(src_addr[(4+r)*RFW +: RFW]), VLEN'((bb + r) % 32));
    end
    @(posedge clk); #2;
    start = 0;
    chk({req, " R7 done"}, VLEN'(done), VLEN'(1));
    chk({req, " R2 wb_en"}, VLEN'(wb_en), q ? VLEN'(4'hf) : VLEN'(4'h3));
    for (int r = 0; r < nr; r++) begin
      chk({req, " R3 wb_addr"}, VLEN'(wb_addr[r*RFW +: RFW]), VLEN'((db + r) % 32));
      chk({req, " R6 data"}, wb_data[r*VLEN +: VLEN], exp[r]);
    end
    for (int r = 0; r < nr; r++) rf[(db + r) % 32] = wb_data[r*VLEN +: VLEN];
    @(posedge clk); #2;
    chk({req, " R7 done drop"}, VLEN'(done), VLEN'(0));
    chk({req, " R2 wb_en idle"}, VLEN'(wb_en), VLEN'(0));
  endtask

  task automatic t_reset;
    chk("R9 done", VLEN'(done), VLEN'(0));
    chk("R9 wb_en", VLEN'(wb_en), VLEN'(0));
    chk("R9 data", wb_data[VLEN-1:0], '0);
  endtask

  task automatic t_hold;
    logic [4*VLEN-1:0] keep = wb_data;
    @(negedge clk);
    srca_fld = 7; srcb_fld = 3; esz = 1; pn_fld = 5; prf[13] = 16'd9;
    @(posedge clk); #2;
    checks++;
    if (wb_data !== keep) begin
      fails++;
      $display("FAIL R8 hold actual=%h expected=%h", wb_data[VLEN-1:0], keep[VLEN-1:0]);
    end
    chk("R7 no start", VLEN'(done), VLEN'(0));
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL R7 watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++)
      for (int w = 0; w < VLEN/32; w++) rf[i][w*32 +: 32] = 32'h9E3779B9 * (i*8 + w + 1);
    for (int i = 0; i < 16; i++) prf[i] = '0;
    repeat (2) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1;
    run_op("R1 bytes", 0, 0, 5, 1, 2, 0, 5);
    run_op("R1 halves", 1, 1, 2, 3, 4, 1, 20);
    run_op("R5 zero", 2, 0, 9, 6, 7, 2, 0);
    run_op("R5 saturate", 3, 1, 5, 0, 1, 3, 1000);
    run_op("R5 cross", 0, 1, 6, 2, 3, 4, 40);
    run_op("R1 words", 2, 1, 7, 4, 6, 6, 9);
    run_op("R8 overlap", 1, 0, 4, 4, 12, 7, 3);
    run_op("R3 wrap", 3, 0, 15, 15, 14, 5, 3);
    t_hold();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule